// File: doc/BRIEF.md
# Redundant Extraction-Referenced Timing Gate Bank

This block produces a bank of timing gates for a pulsed accelerator. It runs on a clock that is locked to the storage ring revolution frequency. A free-running oscillator is not a valid clock source. Every gate is defined by where it ends, not by where it begins. All gates finish at one shared extraction count. Each gate opens a programmed number of clocks earlier. The host writes the extraction count and the per-gate widths into shadow storage. After that, a cycle-start strobe loads them, and every machine cycle then runs with no further host involvement. Many machine cycles make up a super-cycle, and the host only needs to act when it wants new values.

The gate logic is built several times over. Each copy has its own counter and its own copy of the active parameters. A voter compares the copies on every clock and feeds the output from a copy that agrees with the majority. When the selected copy drops out of the majority, the output moves to another copy on the same edge. A sticky flag records that the copies disagreed, and only the host can clear it. A fault-injection input corrupts a chosen copy, so the redundancy can be exercised in system test.

Top module: `extGateBank`

## Requirements
- R1: While reset is asserted and after it is released, `gateOut` is all zero, `activeSet` is 0 and `discrepancy` is 0. No gate appears before the first cycle start.
- R2: Number clock edges from the edge that samples `cycleStart` high; that edge is edge 0. Let E be the active extraction count and W be the active width of gate g. Then `gateOut[g]` is 1 after edge n exactly when n-1 lies in the range from E-W up to, but not including, E.
- R3: A gate whose active width is 0 never goes high. An extraction count of 0 gives no gate on any channel.
- R4: A width equal to or larger than E is clamped. The gate then opens at count 0, which is visible after edge 1, and still closes at E.
- R5: Write address 0 holds the extraction count and write address g+1 holds the width of gate g. Writes go to shadow storage and take effect at the next sampled `cycleStart`. A write in the same cycle as `cycleStart` waits for the cycle start after that one. Writes to addresses above NUM_GATES change nothing.
- R6: With no host writes, every cycle start reproduces the same gate pattern.
- R7: Without a new `cycleStart`, the gates stay low after count E. The counter stops at its maximum value and never wraps.
- R8: A set is in the majority when at least NUM_SETS/2 other sets show an identical gate vector. When the active set is not in the majority, the output registered at that edge comes from the lowest-index majority set. `activeSet` moves to that set on the same edge and never moves back on its own.
- R9: `discrepancy` is set at any edge where two sets show different vectors. It stays set until an edge that has `clrFault` high and no difference between sets. If a difference and `clrFault` fall on the same edge, setting wins.
- R10: `faultInject[s]` inverts every gate bit of set s. A fault on a set that is not active changes neither `gateOut` nor `activeSet`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock locked to the ring revolution |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStart | input | 1 | Machine-cycle start strobe; restarts the counters and loads the shadow values |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | ADDR_W (3) | Write address: 0 is the extraction count, g+1 is the width of gate g |
| wrData | input | CNT_W (16) | Write data |
| clrFault | input | 1 | Clears the sticky discrepancy flag |
| faultInject | input | NUM_SETS (4) | Per-set corruption for test; inverts that set's gates |
| gateOut | output | NUM_GATES (4) | Registered gate outputs from the selected set |
| activeSet | output | SEL_W (2) | Index of the set that currently feeds the output |
| discrepancy | output | 1 | Sticky flag: the sets disagreed |

## Verification
Two pairs of actions can land on the same clock edge. In the first, a host write and a cycle start fall together. The bench drives `wrEn` and `cycleStart` in the same cycle and checks that the cycle which follows still uses the old extraction count, and that the new count shows up only one cycle start later. In the second, a fault and a clear of the flag fall together. The bench raises `clrFault` on the same edge as a single-set fault and expects `discrepancy` to stay set. It also raises `clrFault` alone and expects the flag to drop. The expected gate pattern comes from an edge-by-edge model in the bench that is run across random parameters, random write timing and random single-set faults. That model checks that failover never disturbs `gateOut`.

// File: rtl/extGatePkg.sv
package extGatePkg;

  // Strobes from the control section to each gate datapath replica
  typedef struct packed {
    logic loadParams;    // copy shadow values into the active registers
    logic restartCount;  // zero the cycle counter
  } gateStrobe_t;

endpackage

// File: rtl/extGateCtrl.sv
module extGateCtrl
  import extGatePkg::*;
#(
  parameter int NUM_GATES = 4,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = $clog2(NUM_GATES + 1)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cycleStart,
  input  logic                                wrEn,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [CNT_W-1:0]                    wrData,
  output gateStrobe_t                         strobe,
  output logic [CNT_W-1:0]                    shExt,
  output logic [NUM_GATES-1:0][CNT_W-1:0]     shWidth
);

  localparam logic [ADDR_W-1:0] EXT_ADDR = '0;

  // Shadow copy of the extraction count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shExt <= '0;
    end else if (wrEn && (wrAddr == EXT_ADDR)) begin
      shExt <= wrData;
    end
  end

  // Shadow copies of the gate widths; address g+1 selects gate g
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shWidth <= '0;
    end else if (wrEn) begin
      for (int g = 0; g < NUM_GATES; g++) begin
        if (wrAddr == ADDR_W'(g + 1)) begin
          shWidth[g] <= wrData;
        end
      end
    end
  end

  // A cycle start both restarts counting and commits the shadow values
  always_comb begin
    strobe.loadParams   = cycleStart;
    strobe.restartCount = cycleStart;
  end

endmodule

// File: rtl/extGateSet.sv
module extGateSet
  import extGatePkg::*;
#(
  parameter int NUM_GATES = 4,
  parameter int CNT_W     = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  gateStrobe_t                     strobe,
  input  logic [CNT_W-1:0]                shExt,
  input  logic [NUM_GATES-1:0][CNT_W-1:0] shWidth,
  input  logic                            faultFlip,
  output logic [NUM_GATES-1:0]            gateVec
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]                cnt;
  logic [CNT_W-1:0]                actExt;
  logic [NUM_GATES-1:0][CNT_W-1:0] actWidth;
  logic [NUM_GATES-1:0]            gateRaw;

  // Cycle counter: restarts on cycle start and stops at its ceiling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_MAX;
    end else if (strobe.restartCount) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // Active parameters, loaded only at a cycle start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actExt   <= '0;
      actWidth <= '0;
    end else if (strobe.loadParams) begin
      actExt   <= shExt;
      actWidth <= shWidth;
    end
  end

  // Every gate closes at the extraction count; its opening is counted back
  always_comb begin
    logic [CNT_W-1:0] openAt;
    for (int g = 0; g < NUM_GATES; g++) begin
      openAt     = (actWidth[g] >= actExt) ? '0 : (actExt - actWidth[g]);
      gateRaw[g] = (actWidth[g] != '0) && (cnt >= openAt) && (cnt < actExt);
    end
  end

  assign gateVec = gateRaw ^ {NUM_GATES{faultFlip}};

endmodule

// File: rtl/extGateVote.sv
module extGateVote #(
  parameter int NUM_SETS  = 4,
  parameter int NUM_GATES = 4,
  parameter int SEL_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_SETS-1:0][NUM_GATES-1:0]  setVec,
  input  logic                                clrFault,
  output logic [NUM_GATES-1:0]                gateOut,
  output logic [SEL_W-1:0]                    activeSet,
  output logic                                discrepancy
);

  localparam int QUORUM = NUM_SETS / 2;

  logic [NUM_SETS-1:0]  trusted;
  logic                 anyDiff;
  logic                 haveAlt;
  logic [SEL_W-1:0]     fallback;
  logic [NUM_GATES-1:0] chosen;
  logic                 needSwitch;

  // Pairwise agreement among the replicas
  always_comb begin
    int agree;
    anyDiff = 1'b0;
    for (int s = 1; s < NUM_SETS; s++) begin
      if (setVec[s] != setVec[0]) anyDiff = 1'b1;
    end
    for (int s = 0; s < NUM_SETS; s++) begin
      agree = 0;
      for (int o = 0; o < NUM_SETS; o++) begin
        if ((o != s) && (setVec[o] == setVec[s])) agree = agree + 1;
      end
      trusted[s] = (agree >= QUORUM);
    end
  end

  // Lowest-index set that sits in the majority
  always_comb begin
    haveAlt  = 1'b0;
    fallback = '0;
    for (int s = NUM_SETS - 1; s >= 0; s--) begin
      if (trusted[s]) begin
        haveAlt  = 1'b1;
        fallback = SEL_W'(s);
      end
    end
  end

  assign needSwitch = !trusted[activeSet] && haveAlt;
  assign chosen     = needSwitch ? setVec[fallback] : setVec[activeSet];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOut     <= '0;
      activeSet   <= '0;
      discrepancy <= 1'b0;
    end else begin
      gateOut <= chosen;
      if (needSwitch) activeSet <= fallback;
      if (anyDiff) begin
        discrepancy <= 1'b1;
      end else if (clrFault) begin
        discrepancy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/extGateBank.sv
module extGateBank
  import extGatePkg::*;
#(
  parameter int  NUM_SETS  = 4,
  parameter int  NUM_GATES = 4,
  parameter int  CNT_W     = 16,
  localparam int ADDR_W    = $clog2(NUM_GATES + 1),
  localparam int SEL_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycleStart,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic                 clrFault,
  input  logic [NUM_SETS-1:0]  faultInject,
  output logic [NUM_GATES-1:0] gateOut,
  output logic [SEL_W-1:0]     activeSet,
  output logic                 discrepancy
);

  gateStrobe_t                      strobe;
  logic [CNT_W-1:0]                 shExt;
  logic [NUM_GATES-1:0][CNT_W-1:0]  shWidth;
  logic [NUM_SETS-1:0][NUM_GATES-1:0] setVec;

  extGateCtrl #(
    .NUM_GATES (NUM_GATES),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .strobe     (strobe),
    .shExt      (shExt),
    .shWidth    (shWidth)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    extGateSet #(
      .NUM_GATES (NUM_GATES),
      .CNT_W     (CNT_W)
    ) u_set (
      .clk       (clk),
      .rstN      (rstN),
      .strobe    (strobe),
      .shExt     (shExt),
      .shWidth   (shWidth),
      .faultFlip (faultInject[s]),
      .gateVec   (setVec[s])
    );
  end

  extGateVote #(
    .NUM_SETS  (NUM_SETS),
    .NUM_GATES (NUM_GATES),
    .SEL_W     (SEL_W)
  ) u_vote (
    .clk         (clk),
    .rstN        (rstN),
    .setVec      (setVec),
    .clrFault    (clrFault),
    .gateOut     (gateOut),
    .activeSet   (activeSet),
    .discrepancy (discrepancy)
  );

endmodule

// File: rtl/extGateBankChk.sv
module extGateBankChk #(
  parameter int NUM_SETS  = 4,
  parameter int NUM_GATES = 4,
  parameter int SEL_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               clrFault,
  input logic [NUM_SETS-1:0]                faultInject,
  input logic [NUM_SETS-1:0][NUM_GATES-1:0] setVec,
  input logic [NUM_GATES-1:0]               gateOut,
  input logic [SEL_W-1:0]                   activeSet,
  input logic                               discrepancy
);

  // R2: with no corruption, the registered output follows replica 0
  p_clean_tracks_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(faultInject) == '0) |-> (gateOut == $past(setVec[0])));

  // R8: the selection only moves together with a recorded disagreement
  p_switch_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeSet) |-> discrepancy);

  // R9: a single corrupted set always raises the flag
  p_single_fault_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(faultInject) == 1) |=> discrepancy);

  // R9: the flag holds until a clear request
  p_sticky_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (discrepancy && !clrFault) |=> discrepancy);

  // R10: agreement among all sets never moves the selection
  p_clean_keeps_active_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(faultInject) == '0) |-> $stable(activeSet));

endmodule

bind extGateBank extGateBankChk #(
  .NUM_SETS  (NUM_SETS),
  .NUM_GATES (NUM_GATES),
  .SEL_W     (SEL_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .clrFault    (clrFault),
  .faultInject (faultInject),
  .setVec      (setVec),
  .gateOut     (gateOut),
  .activeSet   (activeSet),
  .discrepancy (discrepancy)
);

// File: tb/test_extGateBank.sv
module test_extGateBank;

  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int NG   = 4;
  localparam int CW   = 16;
  localparam int AW   = 3;
  localparam int SW   = 2;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cycleStart = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic          clrFault = 1'b0;
  logic [NS-1:0] faultInject = '0;
  logic [NG-1:0] gateOut;
  logic [SW-1:0] activeSet;
  logic          discrepancy;

  extGateBank #(.NUM_SETS(NS), .NUM_GATES(NG), .CNT_W(CW)) i_extGateBank (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .clrFault(clrFault),
    .faultInject(faultInject), .gateOut(gateOut), .activeSet(activeSet),
    .discrepancy(discrepancy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  string tag  = "R1";

  // Bench model state
  int shExt = 0;
  int shW [NG];
  int actExt = 0;
  int actW [NG];
  int mCnt = MAXC;
  logic [NG-1:0] expOut = '0;
  int expActive = 0;
  bit expDisc = 1'b0;

  function automatic bit gateFn(int c, int e, int w);
    int st;
    if (w == 0) return 1'b0;
    st = (w >= e) ? 0 : e - w;
    return (c >= st) && (c < e);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: model the edge from the inputs held since the last negedge
  task automatic tick();
    @(posedge clk);
    for (int g = 0; g < NG; g++) expOut[g] = gateFn(mCnt, actExt, actW[g]);
    if (cycleStart) begin
      actExt = shExt;
      for (int g = 0; g < NG; g++) actW[g] = shW[g];
      mCnt = 0;
    end else if (mCnt < MAXC) begin
      mCnt++;
    end
    if (wrEn) begin
      if (wrAddr == 0) shExt = int'(wrData);
      else if (int'(wrAddr) <= NG) shW[int'(wrAddr) - 1] = int'(wrData);
    end
    if (faultInject != '0) expDisc = 1'b1;
    else if (clrFault) expDisc = 1'b0;
    if (faultInject[expActive]) begin
      for (int s = NS - 1; s >= 0; s--) if (!faultInject[s]) expActive = s;
    end
    @(negedge clk);
    chk(gateOut == expOut, tag, "gateOut", int'(gateOut), int'(expOut));
    chk(int'(activeSet) == expActive, "R8", "activeSet", int'(activeSet), expActive);
    chk(discrepancy == expDisc, "R9", "discrepancy", int'(discrepancy), int'(expDisc));
    cycleStart = 1'b0;
    wrEn       = 1'b0;
    clrFault   = 1'b0;
  endtask

  task automatic hostWrite(int addr, int data);
    wrEn   = 1'b1;
    wrAddr = AW'(addr);
    wrData = CW'(data);
    tick();
  endtask

  task automatic runCycle(int len);
    cycleStart = 1'b1;
    tick();
    for (int i = 1; i < len; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int seedVal;
    int len;
    int r;
    seedVal = $urandom(20240611);
    for (int g = 0; g < NG; g++) begin shW[g] = 0; actW[g] = 0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(gateOut == '0, "R1", "gateOut in reset", int'(gateOut), 0);
    chk(activeSet == '0, "R1", "activeSet in reset", int'(activeSet), 0);
    chk(discrepancy == 1'b0, "R1", "discrepancy in reset", int'(discrepancy), 0);
    rstN = 1'b1;
    tag = "R1";
    repeat (4) tick();

    // R5: staged writes do not act before a cycle start
    tag = "R5";
    hostWrite(0, 20);
    hostWrite(1, 5);
    hostWrite(2, 0);
    hostWrite(3, 30);
    hostWrite(4, 20);
    hostWrite(7, 9);   // unused address, must change nothing
    repeat (3) tick();

    // R2, R3, R4: offsets, zero width, clamped width
    tag = "R2,R3,R4";
    runCycle(40);

    // R5: write in the same cycle as the cycle start waits one more cycle
    tag = "R5";
    wrEn = 1'b1; wrAddr = '0; wrData = CW'(35);
    runCycle(45);
    // R6: no host action, pattern repeats with the now-active values
    tag = "R6";
    runCycle(45);
    runCycle(45);

    // R7: no new cycle start, gates stay low past extraction
    tag = "R7";
    runCycle(400);

    // R3: extraction count zero gives no gate at all
    tag = "R3";
    hostWrite(0, 0);
    runCycle(20);
    hostWrite(0, 25);

    // R10: fault on a non-active set
    tag = "R10";
    runCycle(10);
    faultInject = 4'b0100;
    repeat (6) tick();
    faultInject = '0;
    clrFault = 1'b1;        // R9: plain clear
    tick();
    // R9: clear and a new fault on the same edge, setting wins
    faultInject = 4'b0010;
    clrFault = 1'b1;
    tick();
    faultInject = '0;
    repeat (3) tick();
    clrFault = 1'b1;
    tick();

    // R8: fault on the active set, failover without output disturbance
    tag = "R8";
    faultInject = 4'b0001;
    repeat (5) tick();
    faultInject = '0;
    repeat (3) tick();      // no return to set 0
    faultInject = 4'b0010;  // active set 1 faults, lowest clean is set 0
    repeat (4) tick();
    faultInject = '0;
    runCycle(30);

    // Random mix: parameters, write timing, single-set faults, clears
    tag = "R2";
    for (int c = 0; c < 40; c++) begin
      len = 10 + int'($urandom_range(110));
      cycleStart = 1'b1;
      if ($urandom_range(3) == 0) begin
        wrEn = 1'b1; wrAddr = '0; wrData = CW'($urandom_range(60));
      end
      tick();
      for (int i = 1; i < len; i++) begin
        r = int'($urandom_range(15));
        if (r < 3) begin
          wrEn = 1'b1;
          wrAddr = AW'($urandom_range(NG));
          wrData = (wrAddr == '0) ? CW'($urandom_range(60)) : CW'($urandom_range(70));
        end
        if (r == 5) faultInject = NS'(1) << $urandom_range(NS - 1);
        else if (r > 8) faultInject = '0;
        if (r == 7) clrFault = 1'b1;
        tick();
      end
      faultInject = '0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule